// File: doc/BRIEF.md
# Power-Management Function Configuration and SCI Logic

This block holds the configuration-side state of a power-management PCI function. A dword-addressed configuration write port with byte enables updates two I/O base registers and their enable bits. One base places a 128-byte power-management I/O window, the other places a small SMBus window. Each base register keeps a fixed alignment mask and a bit 0 that always reads 1. The decoded bases and the two window enables leave the block as registered outputs, ready for an address decoder.

Inside the power-management window, a byte-wide port reaches a 16-bit event status register and a 16-bit event enable register. Status bits are set by event inputs, including the timer-overflow input, and are cleared by writing 1 to them. Four of the bits (timer, global lock, power button and real-time clock) can raise the system control interrupt. That interrupt is only driven when the interrupt-pin configuration byte is nonzero.

Top module: `pm_func_regs`

## Requirements
- R1: After reset both bases are 0, both windows are disabled, `sci` is 0, and config reads of dwords 0x48 and 0x90 return 0x00000001.
- R2: A write that enables any byte of dword 0x48 merges the enabled bytes, then stores (value & 0xFF80) | 1. The upper 16 bits read 0. `pm_base` equals the stored value & 0xFF80. Without such a write, `pm_base` holds.
- R3: A write that enables any byte of dword 0x90 stores (merged value & 0xFFF0) | 1, with the upper 16 bits reading 0. `smb_base` equals the stored value & 0xFFF0.
- R4: Only the bytes whose `cfg_be` bit is set are changed; `cfg_be[k]` covers `cfg_wdata[8k+7:8k]`.
- R5: Dword 0x40 is a plain 32-bit read/write register, and its bit 15 (bit 7 of byte 0x41) is `pm_win_en`.
- R6: Byte 0xD2 (bits 23:16 of dword 0xD0) keeps only its low 4 bits; its upper 4 bits and the other bytes of that dword read 0. Its bit 0 (dword bit 16) is `smb_win_en`.
- R7: Each `evt_set` bit sets the same status bit. An I/O write to offset 0 (status bits 7:0) or offset 1 (status bits 15:8) clears the bits written as 1. If a set and a clear of the same bit fall in one cycle, the set wins.
- R8: I/O offsets 2 and 3 are plain read/write bytes of the enable register (bits 7:0 and 15:8). Reads of offsets 0 to 3 return the addressed byte, and other offsets read 0. Read data appears one cycle after `io_re`.
- R9: One cycle after the state changes, `sci` is the OR of (status & enable) over bits 0, 5, 8 and 10 only.
- R10: The interrupt-pin byte is bits 15:8 of dword 0x3C and is the only writable byte of that dword. While it is zero, `sci` stays 0.
- R11: While `pm_win_en` is 0, I/O writes change nothing and I/O reads return 0.
- R12: A config read of any dword not named above returns 0. Config read data appears one cycle after `cfg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_waddr | input | 6 | Config write dword index (byte address / 4) |
| cfg_be | input | 4 | Config write byte enables |
| cfg_wdata | input | 32 | Config write data |
| cfg_re | input | 1 | Config read strobe |
| cfg_raddr | input | 6 | Config read dword index |
| cfg_rdata | output | 32 | Registered config read data |
| io_we | input | 1 | PM window byte write strobe |
| io_re | input | 1 | PM window byte read strobe |
| io_addr | input | 7 | Byte offset inside the PM window |
| io_wdata | input | 8 | PM window write data |
| io_rdata | output | 8 | Registered PM window read data |
| evt_set | input | 16 | Event inputs that set status bits (bit 0 is timer overflow) |
| pm_base | output | 16 | Decoded PM window base |
| pm_win_en | output | 1 | PM window enable |
| smb_base | output | 16 | Decoded SMBus window base |
| smb_win_en | output | 1 | SMBus window enable |
| sci | output | 1 | System control interrupt level |

## Verification
Random configuration writes use random byte enables over the named dwords and unnamed ones. This separates a correct byte merge from a whole-dword overwrite, and it shows that the base masks and the forced bit 0 survive partial writes. Random I/O writes are combined in the same cycle with sparse random event pulses, so set-versus-clear priority is exercised. Enable bits outside the four interrupt sources are also set, which would expose a wrong source mask. Directed cases cover the interrupt-pin gate, writes while the window is closed, and the reset values.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int CFG_AW = 6;
  localparam logic [CFG_AW-1:0] DW_INTPIN  = 6'h0F; // byte 0x3C
  localparam logic [CFG_AW-1:0] DW_MISC    = 6'h10; // byte 0x40
  localparam logic [CFG_AW-1:0] DW_PMBASE  = 6'h12; // byte 0x48
  localparam logic [CFG_AW-1:0] DW_SMBBASE = 6'h24; // byte 0x90
  localparam logic [CFG_AW-1:0] DW_SMBCTL  = 6'h34; // byte 0xD0

  // timer(0), global lock(5), power button(8), rtc(10)
  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

  function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pmf_cfg_regs.sv
module pmf_cfg_regs
  import pmf_pkg::*;
#(
  parameter int PM_ALIGN  = 7,
  parameter int SMB_ALIGN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  output logic [15:0]       pm_base,
  output logic              pm_win_en,
  output logic [15:0]       smb_base,
  output logic              smb_win_en,
  output logic              intpin_nz
);
  localparam logic [15:0] PM_MASK  = 16'hFFFF << PM_ALIGN;
  localparam logic [15:0] SMB_MASK = 16'hFFFF << SMB_ALIGN;

  logic [15:0] pmb_q, smb_q;
  logic [31:0] misc_q;
  logic [7:0]  pin_q;
  logic [3:0]  sctl_q;
  logic [31:0] pmb_m, smb_m, misc_m, pin_m, sctl_m;
  logic        hit_pmb, hit_smb, hit_misc, hit_pin, hit_sctl;

  assign hit_pmb  = cfg_we && cfg_waddr == DW_PMBASE  && |cfg_be;
  assign hit_smb  = cfg_we && cfg_waddr == DW_SMBBASE && |cfg_be;
  assign hit_misc = cfg_we && cfg_waddr == DW_MISC;
  assign hit_pin  = cfg_we && cfg_waddr == DW_INTPIN  && cfg_be[1];
  assign hit_sctl = cfg_we && cfg_waddr == DW_SMBCTL  && cfg_be[2];

  assign pmb_m  = byte_merge({16'h0, pmb_q}, cfg_wdata, cfg_be);
  assign smb_m  = byte_merge({16'h0, smb_q}, cfg_wdata, cfg_be);
  assign misc_m = byte_merge(misc_q, cfg_wdata, cfg_be);
  assign pin_m  = byte_merge({16'h0, pin_q, 8'h0}, cfg_wdata, cfg_be);
  assign sctl_m = byte_merge({12'h0, sctl_q, 16'h0}, cfg_wdata, cfg_be);

  always_ff @(posedge clk) begin
    if (rst) begin
      pmb_q  <= 16'h0001;
      smb_q  <= 16'h0001;
      misc_q <= '0;
      pin_q  <= '0;
      sctl_q <= '0;
    end else begin
      if (hit_pmb)  pmb_q  <= (pmb_m[15:0] & PM_MASK) | 16'h0001;
      if (hit_smb)  smb_q  <= (smb_m[15:0] & SMB_MASK) | 16'h0001;
      if (hit_misc) misc_q <= misc_m;
      if (hit_pin)  pin_q  <= pin_m[15:8];
      if (hit_sctl) sctl_q <= sctl_m[19:16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_re) begin
      unique case (cfg_raddr)
        DW_INTPIN:  cfg_rdata <= {16'h0, pin_q, 8'h0};
        DW_MISC:    cfg_rdata <= misc_q;
        DW_PMBASE:  cfg_rdata <= {16'h0, pmb_q};
        DW_SMBBASE: cfg_rdata <= {16'h0, smb_q};
        DW_SMBCTL:  cfg_rdata <= {12'h0, sctl_q, 16'h0};
        default:    cfg_rdata <= '0;
      endcase
    end
  end

  assign pm_base    = pmb_q & PM_MASK;
  assign smb_base   = smb_q & SMB_MASK;
  assign pm_win_en  = misc_q[15];
  assign smb_win_en = sctl_q[0];
  assign intpin_nz  = |pin_q;

  p_pm_base_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_waddr == DW_PMBASE) |=> $stable(pm_base));
  p_smb_base_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_waddr == DW_SMBBASE) |=> $stable(smb_base));
  p_win_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_waddr == DW_MISC && cfg_be[1]) |=> $stable(pm_win_en));
  p_base_bit0_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_raddr == DW_PMBASE) |=> cfg_rdata[0]);
  p_sctl_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_raddr == DW_SMBCTL) |=> cfg_rdata[23:20] == 4'h0);
endmodule

// File: rtl/pmf_evt_regs.sv
module pmf_evt_regs
  import pmf_pkg::*;
#(
  parameter int IO_AW = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_en,
  input  logic             io_we,
  input  logic             io_re,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  input  logic [15:0]      evt_set,
  input  logic             intpin_nz,
  output logic [7:0]       io_rdata,
  output logic             sci
);
  localparam logic [IO_AW-1:0] OFS_STS_LO = IO_AW'(0);
  localparam logic [IO_AW-1:0] OFS_STS_HI = IO_AW'(1);
  localparam logic [IO_AW-1:0] OFS_EN_LO  = IO_AW'(2);
  localparam logic [IO_AW-1:0] OFS_EN_HI  = IO_AW'(3);

  logic [15:0] sts_q, en_q, clr;
  logic        wr_ok;

  assign wr_ok = io_we && win_en;

  always_comb begin
    clr = '0;
    if (wr_ok && io_addr == OFS_STS_LO) clr[7:0]  = io_wdata;
    if (wr_ok && io_addr == OFS_STS_HI) clr[15:8] = io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      sci   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr) | evt_set;
      if (wr_ok && io_addr == OFS_EN_LO) en_q[7:0]  <= io_wdata;
      if (wr_ok && io_addr == OFS_EN_HI) en_q[15:8] <= io_wdata;
      sci <= intpin_nz && |(sts_q & en_q & SCI_SRC_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_re) begin
      if (!win_en) io_rdata <= '0;
      else begin
        unique case (io_addr)
          OFS_STS_LO: io_rdata <= sts_q[7:0];
          OFS_STS_HI: io_rdata <= sts_q[15:8];
          OFS_EN_LO:  io_rdata <= en_q[7:0];
          OFS_EN_HI:  io_rdata <= en_q[15:8];
          default:    io_rdata <= '0;
        endcase
      end
    end
  end

  p_sci_pin_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !intpin_nz |=> !sci);
  p_sci_mask_r9: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & en_q & SCI_SRC_MASK) == 16'h0) |=> !sci);
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && io_addr == OFS_STS_LO && evt_set[7:0] == 8'h0)
      |=> (sts_q[7:0] & $past(io_wdata)) == 8'h0);
  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));
  p_closed_r11: assert property (@(posedge clk) disable iff (rst)
    (!win_en && evt_set == 16'h0) |=> ($stable(sts_q) && $stable(en_q)));
endmodule

// File: rtl/pm_func_regs.sv
module pm_func_regs
  import pmf_pkg::*;
#(
  parameter int PM_ALIGN  = 7,
  parameter int SMB_ALIGN = 4,
  parameter int IO_AW     = PM_ALIGN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [31:0]       cfg_rdata,
  input  logic              io_we,
  input  logic              io_re,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [15:0]       evt_set,
  output logic [15:0]       pm_base,
  output logic              pm_win_en,
  output logic [15:0]       smb_base,
  output logic              smb_win_en,
  output logic              sci
);
  logic intpin_nz;

  pmf_cfg_regs #(.PM_ALIGN(PM_ALIGN), .SMB_ALIGN(SMB_ALIGN)) cfg_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .pm_win_en(pm_win_en),
    .smb_base(smb_base), .smb_win_en(smb_win_en),
    .intpin_nz(intpin_nz)
  );

  pmf_evt_regs #(.IO_AW(IO_AW)) evt_i (
    .clk(clk), .rst(rst), .win_en(pm_win_en),
    .io_we(io_we), .io_re(io_re), .io_addr(io_addr), .io_wdata(io_wdata),
    .evt_set(evt_set), .intpin_nz(intpin_nz),
    .io_rdata(io_rdata), .sci(sci)
  );
endmodule

// File: tb/pm_func_regs_tb_top.sv
module pm_func_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_re, io_we, io_re;
  logic [5:0]  cfg_waddr, cfg_raddr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [6:0]  io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic [15:0] evt_set, pm_base, smb_base;
  logic        pm_win_en, smb_win_en, sci;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_pmb, m_smb, m_sts, m_en;
  logic [31:0] m_misc;
  logic [7:0]  m_pin, m_d2;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_func_regs dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_re(cfg_re), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .io_we(io_we), .io_re(io_re), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .evt_set(evt_set),
    .pm_base(pm_base), .pm_win_en(pm_win_en),
    .smb_base(smb_base), .smb_win_en(smb_win_en), .sci(sci)
  );

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_cfg(input logic [5:0] a);
    case (a)
      6'h0F:   return {16'h0, m_pin, 8'h0};
      6'h10:   return m_misc;
      6'h12:   return {16'h0, m_pmb};
      6'h24:   return {16'h0, m_smb};
      6'h34:   return {8'h0, m_d2, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_io(input logic [6:0] a);
    if (!m_misc[15]) return 8'h0;
    case (a)
      7'd0:    return m_sts[7:0];
      7'd1:    return m_sts[15:8];
      7'd2:    return m_en[7:0];
      7'd3:    return m_en[15:8];
      default: return 8'h0;
    endcase
  endfunction

  function automatic logic exp_sci();
    return (m_pin != 8'h0) && ((m_sts & m_en & 16'h0521) != 16'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_outs();
    @(negedge clk);
    chk("R2 pm_base", {16'h0, pm_base}, {16'h0, m_pmb & 16'hFF80});
    chk("R5 pm_win_en", {31'h0, pm_win_en}, {31'h0, m_misc[15]});
    chk("R3 smb_base", {16'h0, smb_base}, {16'h0, m_smb & 16'hFFF0});
    chk("R6 smb_win_en", {31'h0, smb_win_en}, {31'h0, m_d2[0]});
    chk("R9 R10 sci", {31'h0, sci}, {31'h0, exp_sci()});
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      6'h0F: m_pin = mrg({16'h0, m_pin, 8'h0}, d, be) >> 8;
      6'h10: m_misc = mrg(m_misc, d, be);
      6'h12: if (|be) m_pmb = (mrg({16'h0, m_pmb}, d, be) & 32'hFF80) | 32'h1;
      6'h24: if (|be) m_smb = (mrg({16'h0, m_smb}, d, be) & 32'hFFF0) | 32'h1;
      6'h34: if (be[2]) m_d2 = d[23:16] & 8'h0F;
      default: ;
    endcase
    chk_outs();
  endtask

  task automatic io_write_evt(input logic we, input logic [6:0] a, input logic [7:0] d,
                              input logic [15:0] ev);
    logic [15:0] clr;
    @(negedge clk);
    io_we = we; io_addr = a; io_wdata = d; evt_set = ev;
    @(negedge clk);
    io_we = 0; evt_set = 0;
    clr = 16'h0;
    if (we && m_misc[15]) begin
      if (a == 7'd0) clr[7:0] = d;
      if (a == 7'd1) clr[15:8] = d;
      if (a == 7'd2) m_en[7:0] = d;
      if (a == 7'd3) m_en[15:8] = d;
    end
    m_sts = (m_sts & ~clr) | ev;
    chk_outs();
  endtask

  task automatic cfg_read(input logic [5:0] a);
    @(negedge clk);
    cfg_re = 1; cfg_raddr = a;
    @(negedge clk);
    cfg_re = 0;
    chk("R12 cfg read", cfg_rdata, exp_cfg(a));
  endtask

  task automatic io_read(input logic [6:0] a);
    @(negedge clk);
    io_re = 1; io_addr = a;
    @(negedge clk);
    io_re = 0;
    chk("R8 R11 io read", {24'h0, io_rdata}, {24'h0, exp_io(a)});
  endtask

  function automatic logic [5:0] pick_dw();
    case ($urandom % 7)
      0: return 6'h0F;
      1: return 6'h10;
      2: return 6'h12;
      3: return 6'h24;
      4: return 6'h34;
      5: return 6'h11;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; cfg_we = 0; cfg_re = 0; io_we = 0; io_re = 0;
    cfg_waddr = 0; cfg_raddr = 0; cfg_be = 0; cfg_wdata = 0;
    io_addr = 0; io_wdata = 0; evt_set = 0;
    m_pmb = 16'h1; m_smb = 16'h1; m_sts = 0; m_en = 0; m_misc = 0; m_pin = 0; m_d2 = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 pm_base", {16'h0, pm_base}, 32'h0);
    chk("R1 smb_base", {16'h0, smb_base}, 32'h0);
    chk("R1 windows", {30'h0, pm_win_en, smb_win_en}, 32'h0);
    chk("R1 sci", {31'h0, sci}, 32'h0);
    cfg_read(6'h12);
    chk("R1 pm reg", cfg_rdata, 32'h1);
    cfg_read(6'h24);
    chk("R1 smb reg", cfg_rdata, 32'h1);

    // R2 R3 full writes with masks
    cfg_write(6'h12, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h12);
    chk("R2 stored", cfg_rdata, 32'h0000_FF81);
    cfg_write(6'h24, 4'hF, 32'h1234_ABCD);
    cfg_read(6'h24);
    chk("R3 stored", cfg_rdata, 32'h0000_ABC1);
    // R4 partial write: only byte 1 changes
    cfg_write(6'h12, 4'h2, 32'h0000_1200);
    cfg_read(6'h12);
    chk("R4 partial", cfg_rdata, 32'h0000_1281);
    // R6 upper nibble dropped
    cfg_write(6'h34, 4'hF, 32'hFFFF_FFFF);
    cfg_read(6'h34);
    chk("R6 low nibble", cfg_rdata, 32'h000F_0000);

    // R11 closed window: writes ignored
    io_write_evt(1, 7'd2, 8'hFF, 16'h0);
    io_read(7'd2);
    cfg_write(6'h10, 4'h2, 32'h0000_8000);
    io_read(7'd2);
    chk("R11 en untouched", {24'h0, io_rdata}, 32'h0);

    // R10 pin gate, R9 source mask
    io_write_evt(1, 7'd2, 8'hFF, 16'h0);
    io_write_evt(1, 7'd3, 8'hFF, 16'h0);
    io_write_evt(0, 7'd0, 8'h00, 16'h0002); // bit 1 not an SCI source
    chk("R9 non-source", {31'h0, sci}, 32'h0);
    io_write_evt(0, 7'd0, 8'h00, 16'h0400); // rtc
    chk("R10 no pin", {31'h0, sci}, 32'h0);
    cfg_write(6'h0F, 4'h2, 32'h0000_0100);
    chk("R10 pin set", {31'h0, sci}, 32'h1);
    // R7 set wins over clear in the same cycle
    io_write_evt(1, 7'd1, 8'h04, 16'h0400);
    chk("R7 set wins", {31'h0, sci}, 32'h1);
    io_write_evt(1, 7'd1, 8'h04, 16'h0000);
    chk("R7 cleared", {31'h0, sci}, 32'h0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 4)
        0: begin
          logic [5:0]  a = pick_dw();
          logic [31:0] d = $urandom;
          if (a == 6'h10 && ($urandom % 4) != 0) d[15] = 1'b1;
          cfg_write(a, 4'($urandom), d);
        end
        1: io_write_evt(1'($urandom), 7'($urandom % 6), 8'($urandom),
                        16'($urandom & $urandom & $urandom));
        2: cfg_read(pick_dw());
        default: io_read(7'($urandom % 6));
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule